// File: doc/BRIEF.md
# Command Packet Full Detector

This block sits next to the packet FIFO that receives bytes from the host. It counts the host's write strobes and raises a full-packet flag once the number of bytes received matches an expected length. Firmware uses that flag to learn that a command packet or a short data block has fully arrived, without polling the FIFO fill level itself.

The expected length is captured only when the data-request line rises. If the command/data indicator is high at that edge, the length is the fixed command-packet size of twelve bytes. If it is low, the length is the byte count that firmware has programmed, which must be below twelve. Firmware must set the indicator and the count before it raises data-request, because neither is looked at again until the next rising edge. A FIFO clear empties the byte count. Reset leaves a twelve-byte threshold, an empty count and a low flag.

Top module: `pktfull_top`

## Requirements
- R1: After reset the threshold output is 12, the byte count is 0 and the full flag is 0.
- R2: A write strobe without a clear raises the byte count by exactly one on the next clock edge, unless the count is already 12.
- R3: The byte count never exceeds 12; further write strobes at 12 leave it at 12.
- R4: A FIFO clear sets the byte count to 0 on the next clock edge, and it wins over a write strobe in the same cycle.
- R5: On a clock edge where data-request is high and was low at the previous edge, with the command/data indicator at 1, the threshold becomes 12.
- R6: On such a rising edge with the command/data indicator at 0, the threshold becomes the programmed count (values 0 to 11 taken as they are).
- R7: Without a data-request rising edge the threshold holds, whatever the command/data indicator and the programmed count do.
- R8: The full flag is 1 exactly when the byte count equals the threshold and the threshold is nonzero, apart from the cycle named in R10.
- R9: While the threshold is 0 the full flag stays 0, for any byte count.
- R10: In the cycle after a clock edge that saw a FIFO clear or a data-request rising edge, the full flag is 0.
- R11: A programmed count of 12 to 15 latched with the indicator at 0 yields a threshold of 11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_wr | input | 1 | One byte written by the host into the packet FIFO this cycle |
| xfer_req | input | 1 | Data-request level; its rising edge latches the threshold |
| cmd_sel | input | 1 | Command/data indicator: 1 selects the fixed 12-byte packet |
| byte_goal | input | 4 | Firmware-programmed byte count for data transfers |
| fifo_clr | input | 1 | Empties the byte count |
| pkt_full | output | 1 | Full-packet flag |
| byte_cnt | output | 4 | Bytes received since the last clear |
| goal_q | output | 4 | Latched threshold |

## Verification
The bench goes after the saturation point, where a counter that wrapped past 12 would drop the flag and report a small count, and the clear-plus-write cycle, where the wrong priority would leave a count of one. It raises data-request while the count already matches the new threshold: a design that did not force the flag low for one cycle would hold it high across the new transfer. It changes the indicator and the programmed count with data-request held high, so a level-sensitive latch would move the threshold. A zero threshold with an empty FIFO catches a comparator that ignores the zero case, and a programmed count above eleven catches a missing clamp.

// File: rtl/pktfull_pkg.sv
package pktfull_pkg;
    localparam int PKT_BYTES = 12;
    localparam int CNT_W     = $clog2(PKT_BYTES + 1);
endpackage

// File: rtl/pktfull_edge.sv
module pktfull_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise
);
    typedef struct packed {
        logic last;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.last = level;
        rise      = level & ~st_q.last;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/pktfull_thresh.sv
module pktfull_thresh #(
    parameter int CNT_W     = 4,
    parameter int PKT_BYTES = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise,
    input  logic             cmd_sel,
    input  logic [CNT_W-1:0] byte_goal,
    output logic [CNT_W-1:0] thr_d,
    output logic [CNT_W-1:0] thr_q
);
    localparam logic [CNT_W-1:0] FULL    = CNT_W'(PKT_BYTES);
    localparam logic [CNT_W-1:0] MAXPROG = CNT_W'(PKT_BYTES - 1);

    typedef struct packed {
        logic [CNT_W-1:0] thr;
    } thr_st_t;

    thr_st_t st_d, st_q;
    logic [CNT_W-1:0] prog_lim;

    always_comb begin
        prog_lim = (byte_goal > MAXPROG) ? MAXPROG : byte_goal;
        st_d     = st_q;
        if (rise) st_d.thr = cmd_sel ? FULL : prog_lim;
        thr_d    = st_d.thr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.thr <= FULL;
        else        st_q     <= st_d;
    end

    assign thr_q = st_q.thr;

    p_thr_cmd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && cmd_sel) |=> (thr_q == FULL));
    p_thr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rise |=> $stable(thr_q));
    p_thr_clamp_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && !cmd_sel && byte_goal > MAXPROG) |=> (thr_q == MAXPROG));
endmodule

// File: rtl/pktfull_counter.sv
module pktfull_counter #(
    parameter int CNT_W     = 4,
    parameter int PKT_BYTES = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_wr,
    input  logic             fifo_clr,
    output logic [CNT_W-1:0] cnt_d,
    output logic [CNT_W-1:0] cnt_q
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(PKT_BYTES);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (fifo_clr)                         st_d.cnt = '0;
        else if (host_wr && st_q.cnt < LIMIT) st_d.cnt = st_q.cnt + 1'b1;
        cnt_d = st_d.cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_q = st_q.cnt;

    p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !fifo_clr && cnt_q != LIMIT) |=> (cnt_q == $past(cnt_q) + 1'b1));
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LIMIT);
    p_clr_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_clr |=> (cnt_q == '0));
endmodule

// File: rtl/pktfull_top.sv
module pktfull_top
    import pktfull_pkg::*;
#(
    parameter int PKT_N = PKT_BYTES,
    localparam int CW   = $clog2(PKT_N + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_wr,
    input  logic          xfer_req,
    input  logic          cmd_sel,
    input  logic [CW-1:0] byte_goal,
    input  logic          fifo_clr,
    output logic          pkt_full,
    output logic [CW-1:0] byte_cnt,
    output logic [CW-1:0] goal_q
);
    typedef struct packed {
        logic full;
    } flag_st_t;

    flag_st_t st_d, st_q;
    logic          req_rise;
    logic [CW-1:0] cnt_d, cnt_q, thr_d, thr_q;

    pktfull_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .level (xfer_req),
        .rise  (req_rise)
    );

    pktfull_thresh #(.CNT_W(CW), .PKT_BYTES(PKT_N)) u_thresh (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise      (req_rise),
        .cmd_sel   (cmd_sel),
        .byte_goal (byte_goal),
        .thr_d     (thr_d),
        .thr_q     (thr_q)
    );

    pktfull_counter #(.CNT_W(CW), .PKT_BYTES(PKT_N)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .host_wr  (host_wr),
        .fifo_clr (fifo_clr),
        .cnt_d    (cnt_d),
        .cnt_q    (cnt_q)
    );

    always_comb begin
        st_d      = st_q;
        st_d.full = !req_rise && !fifo_clr && (cnt_d == thr_d) && (thr_d != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pkt_full = st_q.full;
    assign byte_cnt = cnt_q;
    assign goal_q   = thr_q;

    p_flag_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_full |-> (byte_cnt == goal_q));
    p_zero_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (goal_q == '0) |-> !pkt_full);
    p_flag_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_rise || fifo_clr) |=> !pkt_full);
endmodule

// File: tb/tb_pktfull_top.sv
module tb_pktfull_top;
    localparam int CLK_PERIOD = 10;
    localparam int MAXCYC     = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0, xfer_req = 1'b0, cmd_sel = 1'b0, fifo_clr = 1'b0;
    logic [3:0] byte_goal = '0;
    logic       pkt_full;
    logic [3:0] byte_cnt, goal_q;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    pktfull_top dut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .xfer_req(xfer_req),
        .cmd_sel(cmd_sel), .byte_goal(byte_goal), .fifo_clr(fifo_clr),
        .pkt_full(pkt_full), .byte_cnt(byte_cnt), .goal_q(goal_q)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // reference model built from the requirements
    logic       m_req, m_full;
    logic [3:0] m_cnt, m_thr;

    function automatic logic [3:0] exp_thr(logic rise, logic sel, logic [3:0] prog, logic [3:0] old);
        if (!rise) return old;                 // R7
        if (sel)   return 4'd12;               // R5
        return (prog > 4'd11) ? 4'd11 : prog;  // R6, R11
    endfunction

    function automatic logic [3:0] exp_cnt(logic wr, logic clr, logic [3:0] old);
        if (clr) return 4'd0;                           // R4
        if (wr && old < 4'd12) return old + 4'd1;       // R2, R3
        return old;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_req <= 1'b0; m_cnt <= 4'd0; m_thr <= 4'd12; m_full <= 1'b0;
        end else begin
            logic       r;
            logic [3:0] nc, nt;
            r  = xfer_req && !m_req;
            nc = exp_cnt(host_wr, fifo_clr, m_cnt);
            nt = exp_thr(r, cmd_sel, byte_goal, m_thr);
            m_req  <= xfer_req;
            m_cnt  <= nc;
            m_thr  <= nt;
            m_full <= !r && !fifo_clr && nc == nt && nt != 4'd0;  // R8, R9, R10
        end
    end

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cyc(logic wr, logic req, logic sel, logic [3:0] prog, logic clr);
        host_wr = wr; xfer_req = req; cmd_sel = sel; byte_goal = prog; fifo_clr = clr;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (MAXCYC) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        check("R1 thr", goal_q, 12);
        check("R1 cnt", byte_cnt, 0);
        check("R1 flag", pkt_full, 0);
        rst_n = 1'b1;
        @(negedge clk);

        cyc(0, 1, 1, 4'd3, 0);
        check("R5 thr", goal_q, 12);
        check("R10 flag after rise", pkt_full, 0);
        for (int i = 1; i <= 12; i++) begin
            cyc(1, 1, 1, 4'd3, 0);
            check("R2 cnt", byte_cnt, i);
            check("R8 flag", pkt_full, (i == 12));
        end
        cyc(1, 1, 1, 4'd3, 0);
        check("R3 cnt sat", byte_cnt, 12);
        check("R3 flag stays", pkt_full, 1);
        cyc(0, 1, 0, 4'd5, 0);
        check("R7 thr hold", goal_q, 12);
        cyc(1, 1, 0, 4'd5, 1);
        check("R4 clr wins", byte_cnt, 0);
        check("R10 flag after clr", pkt_full, 0);

        cyc(0, 0, 0, 4'd3, 0);
        cyc(0, 1, 0, 4'd3, 0);
        check("R6 thr prog", goal_q, 3);
        for (int i = 1; i <= 3; i++) cyc(1, 1, 0, 4'd9, 0);
        check("R8 flag short", pkt_full, 1);
        cyc(0, 0, 0, 4'd3, 0);
        check("R8 flag keeps on fall", pkt_full, 1);
        cyc(0, 1, 0, 4'd3, 0);
        check("R10 flag drop on rise", pkt_full, 0);
        cyc(0, 1, 0, 4'd3, 0);
        check("R8 flag again", pkt_full, 1);

        cyc(0, 0, 0, 4'd14, 0);
        cyc(0, 1, 0, 4'd14, 0);
        check("R11 clamp", goal_q, 11);
        cyc(0, 0, 0, 4'd0, 1);
        cyc(0, 1, 0, 4'd0, 0);
        check("R6 thr zero", goal_q, 0);
        cyc(0, 1, 0, 4'd0, 0);
        check("R9 zero no flag", pkt_full, 0);
        check("R9 cnt zero", byte_cnt, 0);

        for (int k = 0; k < 4000; k++) begin
            logic wr, rq, sl, cl;
            logic [3:0] pg;
            wr = ($urandom % 4) != 0;
            rq = ($urandom % 8) != 0 ? xfer_req : ~xfer_req;
            sl = $urandom % 2;
            pg = 4'($urandom % 16);
            cl = ($urandom % 16) == 0;
            cyc(wr, rq, sl, pg, cl);
            check("R8 rand flag", pkt_full, m_full);
            check("R2 rand cnt", byte_cnt, m_cnt);
            check("R6 rand thr", goal_q, m_thr);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule